// File: doc/BRIEF.md
# Register-to-Vector Broadcast Unit

This block executes one instruction: it copies the low 8, 16 or 32 bits of a scalar general register into every lane of a 64-bit vector register, or of an aligned pair of vector registers. It takes a 32-bit instruction word, a request strobe and an external condition-pass signal. It drives the index of the wanted scalar register to a 16-entry, 32-bit general register file, which sits outside the block, and it receives that register's contents back in the same cycle. The 32-entry, 64-bit vector register file is inside the block.

Each accepted request completes in one cycle. The unit reports words that are not this instruction, encodings with no defined meaning, and encodings whose result is not predictable. When any of these is reported, the vector file is left untouched. A non-zero reserved field raises a warning, and the write still takes place. A combinational debug port reads back any vector register.

Top module: `vbcast_unit`

## Requirements
- R1: A word is recognised only when bits 27:23 = 11101, bit 20 = 0, bits 11:8 = 1011, bit 6 = 0, bit 4 = 1 and bits 31:28 ≠ 1111. The narrow form with bits 31:24 = 11101110 is included in this rule. Any other word raises `nomatch` and writes nothing.
- R2: The size code is {bit 22, bit 5}. Code 00 fills two 32-bit lanes with scalar[31:0]. Code 01 fills four 16-bit lanes with scalar[15:0]. Code 10 fills eight 8-bit lanes with scalar[7:0]. Lane values carry no sign handling.
- R3: Size code 11 raises `undef` and writes nothing.
- R4: The destination index is {bit 7, bits 19:16}. With bit 21 = 0, only that one register is written.
- R5: With bit 21 = 1, registers d and d+1 both receive the same pattern in the same cycle. With bit 21 = 1 and bit 16 = 1, `undef` is raised and nothing is written.
- R6: `gpr_idx` equals bits 15:12 combinationally. An index of 15 raises `unpred` and writes nothing.
- R7: When bits 3:0 are non-zero on a recognised word, `sbz_warn` is raised and the write still happens.
- R8: A request with `req_valid` = 1 and `cond_pass` = 1 at a rising edge writes at that edge. At the same edge it sets `done` and the flags for exactly one cycle. The flags are never high without `done`.
- R9: A cycle with `req_valid` = 0 or `cond_pass` = 0 writes nothing and raises neither `done` nor any flag.
- R10: `dbg_data` shows vector register `dbg_idx` combinationally. Reset clears all vector registers and all outputs to zero.
- R11: When `nomatch` is raised, `undef`, `unpred` and `sbz_warn` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction request strobe |
| cond_pass | input | 1 | Condition check passed |
| instr | input | 32 | Instruction word |
| gpr_idx | output | 4 | Scalar register file read index |
| gpr_data | input | 32 | Scalar register contents for `gpr_idx` |
| dbg_idx | input | 5 | Debug read index |
| dbg_data | output | 64 | Debug read data |
| done | output | 1 | Request completed pulse |
| nomatch | output | 1 | Word is not this instruction |
| undef | output | 1 | Undefined encoding |
| unpred | output | 1 | Unpredictable encoding |
| sbz_warn | output | 1 | Reserved bits non-zero |

## Verification
An undefined encoding and an unpredictable source index can occur in the same word, and a reserved-bit warning can come with either of them. The sweep covers every combination of size code, pair bit, destination and source index, so words that carry both an undefined size and source index 15 are produced along with the rest. For each request the bench checks that every flag computed from the word rises together with `done`, and that neither register in the destination pair changes. A word that combines an odd pair base, index 15 and non-zero reserved bits is also issued on purpose, and the entire vector file is then compared against the bench's model.

// File: rtl/vbcast_pkg.sv
package vbcast_pkg;
  localparam int INSTR_W = 32;
  localparam int LANE_W  = 8;

  typedef enum logic [1:0] {
    SZ_W32 = 2'b00,
    SZ_H16 = 2'b01,
    SZ_B8  = 2'b10,
    SZ_BAD = 2'b11
  } esize_e;

  typedef struct packed {
    logic       match;
    logic       undef;
    logic       unpred;
    logic       sbz;
    logic       quad;
    esize_e     size;
    logic [4:0] vd;
    logic [3:0] rt;
  } dec_t;
endpackage

// File: rtl/vb_decode.sv
module vb_decode
  import vbcast_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic fixed_ok;

  always_comb begin
    fixed_ok   = (instr[27:23] == 5'b11101) && !instr[20] &&
                 (instr[11:8] == 4'b1011) && !instr[6] && instr[4];
    dec.match  = fixed_ok && (instr[31:28] != 4'hF);
    dec.size   = esize_e'({instr[22], instr[5]});
    dec.quad   = instr[21];
    dec.vd     = {instr[7], instr[19:16]};
    dec.rt     = instr[15:12];
    dec.undef  = dec.match && ((dec.size == SZ_BAD) || (instr[21] && instr[16]));
    dec.unpred = dec.match && (instr[15:12] == 4'hF);
    dec.sbz    = dec.match && (instr[3:0] != 4'h0);
  end
endmodule

// File: rtl/vb_splat.sv
module vb_splat
  import vbcast_pkg::*;
#(
  parameter int VREG_W = 64,
  parameter int GPR_W  = 32
) (
  input  esize_e              size,
  input  logic [GPR_W-1:0]    scalar,
  output logic [VREG_W-1:0]   pattern
);
  localparam int LANES = VREG_W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int W_SEL = g % 4;
    localparam int H_SEL = g % 2;
    always_comb begin
      unique case (size)
        SZ_W32:  pattern[g*LANE_W +: LANE_W] = scalar[W_SEL*LANE_W +: LANE_W];
        SZ_H16:  pattern[g*LANE_W +: LANE_W] = scalar[H_SEL*LANE_W +: LANE_W];
        default: pattern[g*LANE_W +: LANE_W] = scalar[LANE_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/vb_vrf.sv
module vb_vrf #(
  parameter int VREG_N = 32,
  parameter int VREG_W = 64,
  localparam int IDX_W = $clog2(VREG_N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we0,
  input  logic [IDX_W-1:0]         wa0,
  input  logic                     we1,
  input  logic [IDX_W-1:0]         wa1,
  input  logic [VREG_W-1:0]        wd,
  output logic [VREG_N*VREG_W-1:0] regs_flat
);
  for (genvar g = 0; g < VREG_N; g++) begin : g_ent
    logic              en;
    logic [VREG_W-1:0] q;

    always_comb begin
      en = (we0 && (wa0 == IDX_W'(g))) || (we1 && (wa1 == IDX_W'(g)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wd;
    end

    assign regs_flat[g*VREG_W +: VREG_W] = q;
  end

  // R5: the second port only ever writes the odd partner of an even first index
  p_pair_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we1 |-> (we0 && !wa0[0] && (wa1 == (wa0 | IDX_W'(1)))));
endmodule

// File: rtl/vbcast_unit.sv
module vbcast_unit
  import vbcast_pkg::*;
#(
  parameter int VREG_N = 32,
  parameter int VREG_W = 64,
  parameter int GPR_N  = 16,
  parameter int GPR_W  = 32,
  localparam int VIDX_W = $clog2(VREG_N),
  localparam int GIDX_W = $clog2(GPR_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               cond_pass,
  input  logic [INSTR_W-1:0] instr,
  output logic [GIDX_W-1:0]  gpr_idx,
  input  logic [GPR_W-1:0]   gpr_data,
  input  logic [VIDX_W-1:0]  dbg_idx,
  output logic [VREG_W-1:0]  dbg_data,
  output logic               done,
  output logic               nomatch,
  output logic               undef,
  output logic               unpred,
  output logic               sbz_warn
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  dec_t                     dec;
  logic [VREG_W-1:0]        pattern;
  logic [VREG_N*VREG_W-1:0] regs_flat;
  logic [VREG_W-1:0]        view [VREG_N];
  logic                     fire, wr;

  vb_decode u_dec (.instr(instr), .dec(dec));

  assign gpr_idx = dec.rt;

  vb_splat #(.VREG_W(VREG_W), .GPR_W(GPR_W)) u_splat (
    .size(dec.size), .scalar(gpr_data), .pattern(pattern));

  always_comb begin
    fire = req_valid && cond_pass;
    wr   = fire && dec.match && !dec.undef && !dec.unpred;
  end

  vb_vrf #(.VREG_N(VREG_N), .VREG_W(VREG_W)) u_vrf (
    .clk(clk), .rst_n(rst_i_n),
    .we0(wr), .wa0(dec.vd),
    .we1(wr && dec.quad), .wa1({dec.vd[VIDX_W-1:1], 1'b1}),
    .wd(pattern), .regs_flat(regs_flat));

  for (genvar g = 0; g < VREG_N; g++) begin : g_view
    assign view[g] = regs_flat[g*VREG_W +: VREG_W];
  end
  assign dbg_data = view[dbg_idx];

  // status pulses: next-state then register
  logic done_d, nomatch_d, undef_d, unpred_d, sbz_d;

  always_comb begin
    done_d    = fire;
    nomatch_d = fire && !dec.match;
    undef_d   = fire && dec.undef;
    unpred_d  = fire && dec.unpred;
    sbz_d     = fire && dec.sbz;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      done     <= 1'b0;
      nomatch  <= 1'b0;
      undef    <= 1'b0;
      unpred   <= 1'b0;
      sbz_warn <= 1'b0;
    end else begin
      done     <= done_d;
      nomatch  <= nomatch_d;
      undef    <= undef_d;
      unpred   <= unpred_d;
      sbz_warn <= sbz_d;
    end
  end

  // R8: completion only follows an accepted request
  p_done_origin_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> $past(req_valid && cond_pass));
  // R8: no flag without its completion pulse
  p_flag_with_done_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (nomatch || undef || unpred || sbz_warn) |-> done);
  // R9: an idle or condition-failed cycle yields no completion
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(req_valid && cond_pass) |=> !done);
  // R3: an error report coincides with an unchanged vector file
  p_err_keeps_file_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (nomatch || undef || unpred) |-> $stable(regs_flat));
  // R11: a non-matching word raises no other flag
  p_nomatch_alone_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    nomatch |-> (!undef && !unpred && !sbz_warn));
endmodule

// File: tb/vbcast_unit_bench.sv
module vbcast_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, cond_pass;
  logic [31:0] instr;
  logic [3:0]  gpr_idx;
  logic [31:0] gpr_data;
  logic [4:0]  dbg_idx;
  logic [63:0] dbg_data;
  logic        done, nomatch, undef, unpred, sbz_warn;

  logic [31:0] gpr_m [16];
  logic [63:0] exp_m [32];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  assign gpr_data = gpr_m[gpr_idx];

  vbcast_unit u_vbcast_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cond_pass(cond_pass),
    .instr(instr), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
    .dbg_idx(dbg_idx), .dbg_data(dbg_data), .done(done), .nomatch(nomatch),
    .undef(undef), .unpred(unpred), .sbz_warn(sbz_warn));

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [1:0] sz,
                                     input logic q, input logic [4:0] d,
                                     input logic [3:0] rt, input logic [3:0] sbz);
    return {c, 4'b1110, 1'b1, sz[1], q, 1'b0, d[3:0], rt, 4'b1011,
            d[4], 1'b0, sz[0], 1'b1, sbz};
  endfunction

  function automatic logic [63:0] pat(input logic [1:0] sz, input logic [31:0] v);
    case (sz)
      2'b00:   return {2{v}};
      2'b01:   return {4{v[15:0]}};
      default: return {8{v[7:0]}};
    endcase
  endfunction

  // drive at a falling edge, result visible at the next falling edge
  task automatic do_op(input logic [31:0] w, input logic rv, input logic cp);
    instr = w; req_valid = rv; cond_pass = cp;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; cond_pass = 1'b0;
  endtask

  function automatic logic [63:0] flags();
    return {59'd0, done, nomatch, undef, unpred, sbz_warn};
  endfunction

  task automatic peek(input string rq, input logic [4:0] idx);
    dbg_idx = idx;
    #1;
    chk(rq, dbg_data, exp_m[idx]);
  endtask

  task automatic full_compare(input string rq);
    for (int i = 0; i < 32; i++) peek(rq, 5'(i));
  endtask

  initial begin
    logic [31:0] w;
    logic [31:0] bad_masks [5];
    int k;
    bad_masks[0] = 32'h0080_0000; bad_masks[1] = 32'h0010_0000;
    bad_masks[2] = 32'h0000_0100; bad_masks[3] = 32'h0000_0040;
    bad_masks[4] = 32'h0000_0010;
    for (int i = 0; i < 16; i++) gpr_m[i] = 32'h1111_1111 * i;
    for (int i = 0; i < 32; i++) exp_m[i] = '0;
    rst_n = 1'b0; req_valid = 1'b0; cond_pass = 1'b0; instr = '0; dbg_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    chk("R10 reset flags", flags(), 64'd0);
    full_compare("R10 reset file");

    // R6: read index follows bits 15:12 combinationally
    instr = mk(4'hE, 2'b00, 1'b0, 5'd0, 4'd9, 4'd0); #1;
    chk("R6 gpr_idx", {60'd0, gpr_idx}, 64'd9);

    // R2 R3 R4 R5 R6 R8: sweep size, pair bit, destination, source
    k = 0;
    for (int d = 0; d < 32; d++)
      for (int q = 0; q < 2; q++)
        for (int sz = 0; sz < 4; sz++)
          for (int rt = 0; rt < 16; rt++) begin
            logic und, unp;
            k++;
            gpr_m[rt] = 32'h13579BDF ^ (32'(k) * 32'h0102_0305);
            und = (sz == 3) || (q == 1 && d[0]);
            unp = (rt == 15);
            do_op(mk(4'h0 + 4'(k % 15), 2'(sz), q[0], 5'(d), 4'(rt), 4'd0), 1'b1, 1'b1);
            chk("R3 R5 R6 R8 flags", flags(), {59'd0, 1'b1, 1'b0, und, unp, 1'b0});
            if (!und && !unp) begin
              exp_m[d] = pat(2'(sz), gpr_m[rt]);
              if (q == 1) exp_m[d + 1] = pat(2'(sz), gpr_m[rt]);
            end
            peek("R2 R4 R5 dest", 5'(d));
            peek("R4 R5 partner", 5'(d ^ 1));
          end
    full_compare("R4 no stray write");

    // R1: alternative narrow form is accepted
    gpr_m[2] = 32'hCAFE_F00D;
    do_op(mk(4'hE, 2'b10, 1'b0, 5'd20, 4'd2, 4'd0), 1'b1, 1'b1);
    exp_m[20] = {8{8'h0D}};
    chk("R1 narrow form flags", flags(), 64'h10);
    peek("R1 narrow form data", 5'd20);

    // R1 R11: non-matching words
    gpr_m[3] = 32'h0BAD_0BAD;
    do_op(mk(4'hF, 2'b00, 1'b0, 5'd21, 4'd3, 4'd5), 1'b1, 1'b1);
    chk("R1 R11 cond 1111", flags(), 64'h18);
    peek("R1 cond 1111 no write", 5'd21);
    for (int m = 0; m < 5; m++) begin
      do_op(mk(4'h1, 2'b11, 1'b1, 5'd21, 4'd15, 4'd3) ^ bad_masks[m], 1'b1, 1'b1);
      chk("R1 R11 fixed bit", flags(), 64'h18);
      peek("R1 fixed bit no write", 5'd21);
    end

    // R7: reserved bits warn, write proceeds
    gpr_m[4] = 32'h8765_4321;
    do_op(mk(4'h2, 2'b01, 1'b1, 5'd6, 4'd4, 4'd5), 1'b1, 1'b1);
    exp_m[6] = {4{16'h4321}}; exp_m[7] = {4{16'h4321}};
    chk("R7 warn flags", flags(), 64'h11);
    peek("R7 write low", 5'd6);
    peek("R7 write high", 5'd7);

    // R3 R5 R6 R7: all error flags in one word
    do_op(mk(4'h3, 2'b11, 1'b1, 5'd9, 4'd15, 4'd8), 1'b1, 1'b1);
    chk("R3 R5 R6 R7 combined", flags(), 64'h17);
    full_compare("R3 combined file unchanged");

    // R9: condition failed or no request
    gpr_m[5] = 32'hDEAD_BEEF;
    w = mk(4'h4, 2'b00, 1'b0, 5'd12, 4'd5, 4'd1);
    do_op(w, 1'b1, 1'b0);
    chk("R9 cond fail flags", flags(), 64'd0);
    peek("R9 cond fail data", 5'd12);
    do_op(w, 1'b0, 1'b1);
    chk("R9 no request flags", flags(), 64'd0);
    peek("R9 no request data", 5'd12);
    @(negedge clk);
    chk("R8 single pulse", flags(), 64'd0);

    finish_run();
  end
endmodule